// File: doc/BRIEF.md
# Reference Phase-Offset Corrector

This block sits in front of the phase detector of a digital PLL. It turns the falling edges of the selected timing reference into a virtual reference strobe. That strobe is the reference delayed by a stored offset, counted in master-clock ticks modulo one frame. When the surrounding control logic switches reference or leaves holdover, it pulses `capture`. The block then stores the tick distance from the most recent reference edge to the next output frame edge. From then on the virtual reference lines up with the output frame, so the switch causes no phase step at the output.

A pulse on `clear` starts a slow walk of the stored offset back to zero. The walk moves one tick per `STEP_INTERVAL` clock cycles. Set this parameter so that one tick per interval stays within the 5 ns per 125 us frame budget. For example, with a 125 us frame of `FRAME_TICKS` ticks, one tick spans 125 us / `FRAME_TICKS`, and the interval spans at least (tick / 5 ns) frames. The walk always takes the shorter way around the frame. A fresh capture during the walk replaces the offset and ends the walk.

All inputs and outputs are single-cycle strobes or plain levels. No data stream crosses the block, so there is no valid/ready pair and no back-pressure. A strobe that arrives is always taken in the cycle it is sampled.

Top module: `phase_offset_corrector`

## Requirements
- R1: While `rst_n` is low, `delay_ticks` is 0, `offset_active` is 0 and `vref_pulse` is 0.
- R2: Each falling edge of `ref_in` produces exactly one `vref_pulse`, high for one cycle. With a stored delay D, the pulse is high in the cycle after the (2+D)-th rising clock edge that follows the cycle in which the low level is first presented.
- R3: A `capture` strobe sets the delay to (FRAME_TICKS − p) mod FRAME_TICKS, visible one cycle later. Here p is the frame position of the latest reference event. The frame position is 0 in a cycle with `frame_pulse` high and counts up by 1 per cycle otherwise, wrapping at FRAME_TICKS. After the capture, the virtual reference strobe comes one cycle after the frame strobe.
- R4: `delay_ticks` is always below FRAME_TICKS.
- R5: A `clear` strobe starts slewing. The first one-tick change lands STEP_INTERVAL rising edges after the edge that samples `clear`, and later changes follow every STEP_INTERVAL edges. No two slew changes are closer than STEP_INTERVAL cycles.
- R6: While slewing, a delay of at most FRAME_TICKS/2 decreases by one per step. A larger delay increases by one per step and wraps from FRAME_TICKS−1 to 0.
- R7: Slewing stops at zero. A `clear` strobe while the delay is zero leaves it zero.
- R8: A `capture` during slewing loads the new offset and ends the slew, so the delay then holds its captured value.
- R9: `offset_active` is high exactly when the stored delay is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Selected timing reference; falling edges are events |
| frame_pulse | input | 1 | One-cycle strobe marking the output frame edge |
| capture | input | 1 | Strobe: store a new offset from the latest reference event |
| clear | input | 1 | Strobe: start slewing the offset back to zero |
| vref_pulse | output | 1 | Virtual reference strobe, the delayed reference event |
| delay_ticks | output | $clog2(FRAME_TICKS) | Stored offset in ticks |
| offset_active | output | 1 | High while the stored offset is non-zero |

## Verification
The checker watches, on every cycle, that the offset stays inside one frame and changes by at most one tick outside a capture. It also checks that the offset moves only in the shorter-path direction for its half of the frame and that slew steps are never closer than the step interval. The bench scenarios are the only place to see the exact capture value, the alignment of the virtual reference to the frame edge, the latency of the strobe, and the step timing after a clear. The same holds for convergence to zero, the no-op clear and the overwrite during a slew.

// File: rtl/pocr_pkg.sv
package pocr_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_DOWN = 2'd1,
    DIR_UP   = 2'd2
  } slew_dir_e;

  // Shorter way home: lower half walks down, upper half walks up and wraps.
  function automatic slew_dir_e pick_dir(input int unsigned d, input int unsigned frame);
    if (d == 0) return DIR_HOLD;
    else if (d <= frame / 2) return DIR_DOWN;
    else return DIR_UP;
  endfunction

endpackage

// File: rtl/pocr_ref_tracker.sv
module pocr_ref_tracker #(
  parameter int FRAME_TICKS = 200
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ref_in,
  input  logic                           frame_pulse,
  output logic                           fall_evt,
  output logic [$clog2(FRAME_TICKS)-1:0] ref_phase
);
  localparam int PW = $clog2(FRAME_TICKS);
  localparam logic [PW-1:0] LAST = PW'(FRAME_TICKS - 1);

  logic          ref_q, ref_qq;
  logic [PW-1:0] pos, cur_phase;

  assign cur_phase = frame_pulse ? '0 : pos;
  assign fall_evt  = ref_qq & ~ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q     <= 1'b0;
      ref_qq    <= 1'b0;
      pos       <= '0;
      ref_phase <= '0;
    end else begin
      ref_q  <= ref_in;
      ref_qq <= ref_q;
      pos    <= (cur_phase == LAST) ? '0 : cur_phase + 1'b1;
      if (fall_evt) ref_phase <= cur_phase;
    end
  end
endmodule

// File: rtl/pocr_offset_ctrl.sv
module pocr_offset_ctrl
  import pocr_pkg::*;
#(
  parameter int FRAME_TICKS   = 200,
  parameter int STEP_INTERVAL = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           capture,
  input  logic                           clear,
  input  logic [$clog2(FRAME_TICKS)-1:0] ref_phase,
  output logic [$clog2(FRAME_TICKS)-1:0] delay
);
  localparam int PW = $clog2(FRAME_TICKS);
  localparam int TW = (STEP_INTERVAL > 1) ? $clog2(STEP_INTERVAL) : 1;
  localparam logic [PW-1:0] LAST     = PW'(FRAME_TICKS - 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(STEP_INTERVAL - 1);

  logic          slewing;
  logic [TW-1:0] tmr;
  logic [PW-1:0] stepped;
  slew_dir_e     dir;

  always_comb begin
    dir = pick_dir(32'(delay), FRAME_TICKS);
    unique case (dir)
      DIR_DOWN: stepped = delay - 1'b1;
      DIR_UP:   stepped = (delay == LAST) ? '0 : delay + 1'b1;
      default:  stepped = delay;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay   <= '0;
      slewing <= 1'b0;
      tmr     <= '0;
    end else if (capture) begin
      delay   <= (ref_phase == '0) ? '0 : PW'(FRAME_TICKS) - ref_phase;
      slewing <= 1'b0;
      tmr     <= '0;
    end else if (clear) begin
      slewing <= 1'b1;
      tmr     <= '0;
    end else if (slewing) begin
      if (delay == '0) begin
        slewing <= 1'b0;
      end else if (tmr == TMR_LAST) begin
        tmr   <= '0;
        delay <= stepped;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pocr_delay_line.sv
module pocr_delay_line #(
  parameter int FRAME_TICKS = 200
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fall_evt,
  input  logic [$clog2(FRAME_TICKS)-1:0] delay,
  output logic                           vref
);
  localparam int PW = $clog2(FRAME_TICKS);

  logic          pend;
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      cnt  <= '0;
      vref <= 1'b0;
    end else if (fall_evt) begin
      pend <= (delay != '0);
      cnt  <= delay - 1'b1;
      vref <= (delay == '0);
    end else if (pend) begin
      vref <= (cnt == '0);
      pend <= (cnt != '0);
      cnt  <= cnt - 1'b1;
    end else begin
      vref <= 1'b0;
    end
  end
endmodule

// File: rtl/phase_offset_corrector.sv
module phase_offset_corrector #(
  parameter int FRAME_TICKS   = 200,
  parameter int STEP_INTERVAL = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ref_in,
  input  logic                           frame_pulse,
  input  logic                           capture,
  input  logic                           clear,
  output logic                           vref_pulse,
  output logic [$clog2(FRAME_TICKS)-1:0] delay_ticks,
  output logic                           offset_active
);
  localparam int PW = $clog2(FRAME_TICKS);

  logic          fall_evt;
  logic [PW-1:0] ref_phase;

  pocr_ref_tracker #(.FRAME_TICKS(FRAME_TICKS)) u_track (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .frame_pulse(frame_pulse),
    .fall_evt(fall_evt), .ref_phase(ref_phase)
  );

  pocr_offset_ctrl #(.FRAME_TICKS(FRAME_TICKS), .STEP_INTERVAL(STEP_INTERVAL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .capture(capture), .clear(clear),
    .ref_phase(ref_phase), .delay(delay_ticks)
  );

  pocr_delay_line #(.FRAME_TICKS(FRAME_TICKS)) u_dly (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .delay(delay_ticks),
    .vref(vref_pulse)
  );

  assign offset_active = (delay_ticks != '0);
endmodule

// File: rtl/pocr_checker.sv
module pocr_checker #(
  parameter int FRAME_TICKS   = 200,
  parameter int STEP_INTERVAL = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           capture,
  input logic [$clog2(FRAME_TICKS)-1:0] delay_ticks
);
  localparam int PW   = $clog2(FRAME_TICKS);
  localparam int HALF = FRAME_TICKS / 2;
  localparam logic [PW-1:0] LAST = PW'(FRAME_TICKS - 1);

  logic [PW-1:0] prev_d;
  logic [31:0]   gap;
  logic          cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_d <= '0;
      gap    <= 32'(STEP_INTERVAL);
      cap_q  <= 1'b0;
    end else begin
      prev_d <= delay_ticks;
      cap_q  <= capture;
      if (delay_ticks != prev_d) gap <= 32'd1;
      else if (gap < 32'(STEP_INTERVAL)) gap <= gap + 32'd1;
    end
  end

  // R4
  delay_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(delay_ticks) < FRAME_TICKS);

  // R5
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> (delay_ticks == $past(delay_ticks)) ||
                 (32'(delay_ticks) + 32'd1 == 32'($past(delay_ticks))) ||
                 (32'(delay_ticks) == 32'($past(delay_ticks)) + 32'd1) ||
                 ($past(delay_ticks) == LAST && delay_ticks == '0));

  // R5
  step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_ticks != prev_d && !cap_q) |-> gap >= 32'(STEP_INTERVAL));

  // R6
  walk_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_ticks != '0 && 32'(delay_ticks) <= HALF && !capture)
      |=> 32'(delay_ticks) <= 32'($past(delay_ticks)));

  // R6
  walk_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(delay_ticks) > HALF && !capture)
      |=> (delay_ticks == '0 || delay_ticks >= $past(delay_ticks)));
endmodule

bind phase_offset_corrector pocr_checker #(
  .FRAME_TICKS(FRAME_TICKS), .STEP_INTERVAL(STEP_INTERVAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .capture(capture), .delay_ticks(delay_ticks)
);

// File: tb/phase_offset_corrector_test.sv
module phase_offset_corrector_test;
  localparam int F    = 200;
  localparam int S    = 16;
  localparam int HALF = F / 2;
  localparam int PW   = $clog2(F);

  logic clk = 1'b0;
  logic rst_n, ref_in, frame_pulse, capture, clear;
  logic vref_pulse, offset_active;
  logic [PW-1:0] delay_ticks;

  int total = 0, bad = 0;
  int t = F - 1, rf = 37, vref_t = -1, vref_cnt = 0;
  bit done = 0;

  phase_offset_corrector #(.FRAME_TICKS(F), .STEP_INTERVAL(S)) uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .frame_pulse(frame_pulse),
    .capture(capture), .clear(clear), .vref_pulse(vref_pulse),
    .delay_ticks(delay_ticks), .offset_active(offset_active)
  );

  always #5 clk = ~clk;

  initial begin
    ref_in = 1'b1;
    frame_pulse = 1'b0;
  end

  // Frame stimulus: frame strobe at index 0, reference falls at index rf.
  always @(negedge clk) begin
    int nt;
    nt = (t + 1) % F;
    if (vref_pulse) begin
      vref_t = nt;
      vref_cnt++;
    end
    t = nt;
    frame_pulse = (t == 0);
    ref_in = (((t + F - rf) % F) >= HALF);
  end

  function automatic int exp_delay(input int r);
    return (F - ((r + 1) % F)) % F;
  endfunction

  function automatic int slew_exp(input int d0, input int n);
    if (d0 == 0) return 0;
    if (d0 <= HALF) return (d0 > n) ? d0 - n : 0;
    return (d0 + n >= F) ? 0 : d0 + n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_frames(input int n);
    repeat (n * F) @(negedge clk);
  endtask

  task automatic pulse_capture();
    @(negedge clk) capture = 1'b1;
    @(negedge clk) capture = 1'b0;
  endtask

  task automatic check_vref(input int exp_t, input string req);
    wait_frames(1);
    vref_cnt = 0;
    wait_frames(1);
    check(vref_cnt == 1, req, vref_cnt, 1);
    check(vref_t == exp_t, req, vref_t, exp_t);
  endtask

  // Capture an offset, clear it, and follow the walk step by step.
  task automatic slew_case(input int r, input string req);
    int d0;
    rf = r;
    wait_frames(2);
    pulse_capture();
    d0 = exp_delay(r);
    check(int'(delay_ticks) == d0, "R3", int'(delay_ticks), d0);
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
    for (int k = 1; k <= 3 * S; k++) begin
      @(negedge clk);
      if (k == S - 1 || k == S)
        check(int'(delay_ticks) == slew_exp(d0, k / S), "R5",
              int'(delay_ticks), slew_exp(d0, k / S));
      if (k == 3 * S)
        check(int'(delay_ticks) == slew_exp(d0, 3), req,
              int'(delay_ticks), slew_exp(d0, 3));
    end
    repeat ((HALF + 2) * S) @(negedge clk);
    check(delay_ticks == '0, "R7", int'(delay_ticks), 0);
    check(offset_active == 1'b0, "R9", int'(offset_active), 0);
  endtask

  initial begin
    int d, d2;
    void'($urandom(32'd2024));
    rst_n = 1'b0; capture = 1'b0; clear = 1'b0;
    repeat (5) @(negedge clk);
    check(delay_ticks == '0, "R1", int'(delay_ticks), 0);
    check(offset_active == 1'b0, "R1", int'(offset_active), 0);
    check(vref_pulse == 1'b0, "R1", int'(vref_pulse), 0);
    rst_n = 1'b1;
    wait_frames(2);

    // R2: zero delay, strobe two edges after the fall
    check_vref((rf + 2) % F, "R2");

    // R3: random reference phases, capture aligns to the frame strobe
    for (int i = 0; i < 4; i++) begin
      rf = $urandom_range(0, F - 1);
      wait_frames(2);
      pulse_capture();
      d = exp_delay(rf);
      check(int'(delay_ticks) == d, "R3", int'(delay_ticks), d);
      check(offset_active == (d != 0), "R9", int'(offset_active), int'(d != 0));
      check_vref(1, "R3");
      // R2 with a non-zero delay: the strobe lags the fall by 2 + D
      check(vref_t == (rf + 2 + d) % F, "R2", vref_t, (rf + 2 + d) % F);
    end

    // R6: direction around the half-frame boundary and the wrap
    slew_case(F - 1 - HALF, "R6");
    slew_case(F - 2 - HALF, "R6");
    slew_case(0, "R6");
    slew_case(F - 2, "R6");
    slew_case($urandom_range(0, F - 1), "R6");

    // R7: clear with zero offset is a no-op
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
    repeat (2 * S + 3) @(negedge clk);
    check(delay_ticks == '0, "R7", int'(delay_ticks), 0);

    // R8: capture during a slew replaces the offset and ends the walk
    rf = F - 1 - HALF - 20;
    wait_frames(2);
    pulse_capture();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
    repeat (2 * S + 2) @(negedge clk);
    check(int'(delay_ticks) == HALF + 22, "R6", int'(delay_ticks), HALF + 22);
    rf = 50;
    wait_frames(2);
    pulse_capture();
    d2 = exp_delay(50);
    check(int'(delay_ticks) == d2, "R8", int'(delay_ticks), d2);
    repeat (3 * S) @(negedge clk);
    check(int'(delay_ticks) == d2, "R8", int'(delay_ticks), d2);
    check(offset_active == 1'b1, "R9", int'(offset_active), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule